// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block receives one memory instruction from a 32-lane warp in a single cycle. Each lane gives a byte address. All lanes share an active-lane mask and an element size. The block decides for the warp as a whole whether the active lanes form one ascending, contiguous run in lane order.

If they do, it splits the run into transactions as wide as the memory bus, 48 bytes by default (384 bits). If they do not, or if the element size is one that is never merged, it issues one narrow transaction per active lane in ascending lane order.

Transactions leave one per cycle on a valid/ready port. Each one carries a start address, a byte count, a mask of the lanes it serves and a last flag. A new warp request is accepted only once the previous request's final transaction has been taken.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is high and txn_valid is low.
- R2: A request is merged only when all of the following hold:
  - the size code is 2 (4-byte) or 3 (8-byte);
  - the mask is nonzero;
  - every active lane k has the address base + k·esize, where base is the lowest active lane's address minus its lane index times esize.
  Any other request takes the per-lane path.
- R3: A merged request emits chunks. The first starts at the lowest active lane's address, and each later chunk starts BUS_BYTES further on. Each chunk's byte count is the smaller of BUS_BYTES and the bytes left up to the end of the highest active lane's element. A full warp of 4-byte elements at 0x1000 gives three chunks: 48, 48 and 32 bytes.
- R4: The lane mask of a merged chunk has bit k set exactly for the active lanes whose element lies inside that chunk.
- R5: A full warp of 8-byte elements is merged into six chunks: five of 48 bytes and a final one of 16 bytes.
- R6: Size codes 0 (1-byte) and 1 (2-byte) are never merged, even when the addresses are contiguous.
- R7: A request whose derived base is not a multiple of the element size takes the per-lane path.
- R8: On the per-lane path, each active lane gets one transaction, in ascending lane order. The transaction carries that lane's address, a byte count equal to the element size, and a one-hot lane mask.
- R9: The addresses of inactive lanes do not affect the merge decision, and inactive lanes never appear in a lane mask.
- R10: txn_last is high on the final transaction of a request and on no other.
- R11: req_ready stays low from acceptance until the final transaction is taken. While txn_valid is high and txn_ready is low, the transaction outputs hold their values.
- R12: A request with an all-zero mask is accepted, produces no transaction, and leaves req_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | LANES*AW | Lane byte addresses, lane k at bits [k*AW +: AW] |
| req_mask | input | LANES | Active-lane mask |
| req_size | input | 2 | Element size code: 0=1B, 1=2B, 2=4B, 3=8B |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_addr | output | AW | Transaction start byte address |
| txn_bytes | output | BYTES_W | Valid byte count |
| txn_lanes | output | LANES | Lanes served by the transaction |
| txn_last | output | 1 | Final transaction of the request |

## Verification
The bench uses several address patterns, each chosen to tell one outcome from another:
- **Full warps of 4-byte and 8-byte elements** check chunk boundaries and the partial last chunk.
- **A sparse mask with garbage addresses in inactive lanes** checks that holes neither block merging nor leak into lane masks.
- **Contiguous byte and halfword accesses** separate the size rule from the ordering rule.
- **A run offset by two bytes** separates the alignment rule from the ordering rule.
- **Reversed lane order** confirms the per-lane path and its order.
- **Back-pressure on the output port and an empty mask** check the handshake.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DWORD = 2'd3
    } elem_size_e;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_WIDE = 2'd1,
        MODE_LANE = 2'd2
    } coal_mode_e;

    // Only 4- and 8-byte elements are eligible for wide merging.
    function automatic logic size_mergeable(input elem_size_e sz);
        return (sz == SZ_WORD) || (sz == SZ_DWORD);
    endfunction

endpackage

// File: rtl/coal_check.sv
module coal_check
    import coal_pkg::*;
#(
    parameter int LANES = 32,
    parameter int AW    = 32,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [LANES-1:0]    mask,
    input  elem_size_e          size,
    output logic                merge_ok,
    output logic [LW-1:0]       lo_idx,
    output logic [LW-1:0]       hi_idx,
    output logic [AW-1:0]       base
);
    logic [AW-1:0] la [LANES];
    logic          any_act;
    logic          in_order;
    logic          aligned;

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign la[g] = addr_flat[g*AW +: AW];
    end

    always_comb begin
        lo_idx  = '0;
        hi_idx  = '0;
        any_act = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (mask[k]) begin
                if (!any_act) lo_idx = LW'(k);
                any_act = 1'b1;
                hi_idx  = LW'(k);
            end
        end
    end

    assign base = la[lo_idx] - (AW'(lo_idx) << size);

    always_comb begin
        in_order = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (mask[k] && (la[k] != base + (AW'(k) << size))) in_order = 1'b0;
        end
    end

    assign aligned  = ((base & ((AW'(1) << size) - AW'(1))) == '0);
    assign merge_ok = any_act && size_mergeable(size) && in_order && aligned;

endmodule

// File: rtl/coal_pick.sv
module coal_pick #(
    parameter int LANES = 32,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    output logic [LW-1:0]    idx,
    output logic [LANES-1:0] onehot,
    output logic             only_one
);
    always_comb begin
        idx = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (pend[k]) idx = LW'(k);
        end
    end

    assign onehot   = pend & (~pend + LANES'(1));
    assign only_one = ((pend & (pend - LANES'(1))) == '0);

endmodule

// File: rtl/coal_chunk.sv
module coal_chunk #(
    parameter int LANES     = 32,
    parameter int BUS_BYTES = 48,
    parameter int OW        = 10,
    parameter int BYTES_W   = 6
) (
    input  logic [OW-1:0]      cur_off,
    input  logic [OW-1:0]      end_off,
    input  logic [1:0]         shamt,
    input  logic [LANES-1:0]   act,
    output logic [BYTES_W-1:0] bytes,
    output logic [LANES-1:0]   lanes,
    output logic               last
);
    logic [OW-1:0] left;
    logic [OW-1:0] lim;

    assign left  = end_off - cur_off;
    assign last  = (left <= OW'(BUS_BYTES));
    assign bytes = last ? BYTES_W'(left) : BYTES_W'(BUS_BYTES);
    assign lim   = cur_off + OW'(bytes);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [OW-1:0] off;
        assign off      = OW'(g) << shamt;
        assign lanes[g] = act[g] && (off >= cur_off) && (off < lim);
    end

    // R9
    always_comb begin
        inactive_lane_chk: assert ((lanes & ~act) == '0);
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int AW        = 32,
    parameter int BUS_BYTES = 48,
    parameter int BYTES_W   = $clog2(BUS_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [LANES-1:0]    req_mask,
    input  logic [1:0]          req_size,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [AW-1:0]       txn_addr,
    output logic [BYTES_W-1:0]  txn_bytes,
    output logic [LANES-1:0]    txn_lanes,
    output logic                txn_last
);
    localparam int LW = $clog2(LANES);
    localparam int OW = $clog2(LANES * 8 + BUS_BYTES) + 1;

    coal_mode_e    mode_q;
    elem_size_e    size_q;
    logic [AW-1:0] base_q;
    logic [OW-1:0] cur_q;
    logic [OW-1:0] end_q;
    logic [LANES-1:0] act_q;
    logic [LANES-1:0] pend_q;
    logic [AW-1:0] lane_q [LANES];

    logic          merge_ok;
    logic [LW-1:0] lo_idx;
    logic [LW-1:0] hi_idx;
    logic [AW-1:0] base_c;

    coal_check #(.LANES(LANES), .AW(AW)) u_check (
        .addr_flat (req_addr),
        .mask      (req_mask),
        .size      (elem_size_e'(req_size)),
        .merge_ok  (merge_ok),
        .lo_idx    (lo_idx),
        .hi_idx    (hi_idx),
        .base      (base_c)
    );

    logic [LW-1:0]    pick_idx;
    logic [LANES-1:0] pick_oh;
    logic             pick_last;

    coal_pick #(.LANES(LANES)) u_pick (
        .pend     (pend_q),
        .idx      (pick_idx),
        .onehot   (pick_oh),
        .only_one (pick_last)
    );

    logic [BYTES_W-1:0] ch_bytes;
    logic [LANES-1:0]   ch_lanes;
    logic               ch_last;

    coal_chunk #(.LANES(LANES), .BUS_BYTES(BUS_BYTES), .OW(OW), .BYTES_W(BYTES_W)) u_chunk (
        .cur_off (cur_q),
        .end_off (end_q),
        .shamt   (size_q),
        .act     (act_q),
        .bytes   (ch_bytes),
        .lanes   (ch_lanes),
        .last    (ch_last)
    );

    logic accept;
    logic take;

    assign req_ready = (mode_q == MODE_IDLE);
    assign txn_valid = (mode_q != MODE_IDLE);
    assign accept    = req_valid && req_ready;
    assign take      = txn_valid && txn_ready;

    always_comb begin
        if (mode_q == MODE_WIDE) begin
            txn_addr  = base_q + AW'(cur_q);
            txn_bytes = ch_bytes;
            txn_lanes = ch_lanes;
            txn_last  = ch_last;
        end else begin
            txn_addr  = lane_q[pick_idx];
            txn_bytes = BYTES_W'(1) << size_q;
            txn_lanes = (mode_q == MODE_LANE) ? pick_oh : '0;
            txn_last  = (mode_q == MODE_LANE) && pick_last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_IDLE;
            size_q <= SZ_BYTE;
            base_q <= '0;
            cur_q  <= '0;
            end_q  <= '0;
            act_q  <= '0;
            pend_q <= '0;
        end else if (accept) begin
            size_q <= elem_size_e'(req_size);
            act_q  <= req_mask;
            pend_q <= req_mask;
            base_q <= base_c;
            cur_q  <= OW'(lo_idx) << req_size;
            end_q  <= (OW'(hi_idx) + OW'(1)) << req_size;
            if (req_mask == '0)  mode_q <= MODE_IDLE;
            else if (merge_ok)   mode_q <= MODE_WIDE;
            else                 mode_q <= MODE_LANE;
        end else if (take) begin
            if (txn_last) begin
                mode_q <= MODE_IDLE;
            end else if (mode_q == MODE_WIDE) begin
                cur_q <= cur_q + OW'(BUS_BYTES);
            end
            pend_q <= pend_q & ~pick_oh;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (accept) lane_q[g] <= req_addr[g*AW +: AW];
        end
    end

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr)
            && $stable(txn_bytes) && $stable(txn_lanes) && $stable(txn_last));

    // R3
    bytes_range_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_bytes != '0) && (txn_bytes <= BYTES_W'(BUS_BYTES)));

    // R8
    lane_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_LANE) |-> $countones(txn_lanes) == 1);

    // R10
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && txn_ready && txn_last |=> !txn_valid && req_ready);

    // R12
    empty_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_mask == '0) |=> req_ready && !txn_valid);

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_mask != '0) |=> txn_valid && !req_ready);

endmodule

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int BW    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [LANES-1:0] req_mask = '0;
    logic [1:0] req_size = 2'd0;
    logic txn_valid;
    logic txn_ready = 1'b0;
    logic [AW-1:0] txn_addr;
    logic [BW-1:0] txn_bytes;
    logic [LANES-1:0] txn_lanes;
    logic txn_last;

    always #5 clk = ~clk;

    warp_coalescer uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .req_size(req_size),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_addr(txn_addr), .txn_bytes(txn_bytes),
        .txn_lanes(txn_lanes), .txn_last(txn_last)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [AW-1:0] lane_a [LANES];
    logic [AW-1:0] g_addr [64];
    logic [BW-1:0] g_bytes [64];
    logic [LANES-1:0] g_lanes [64];
    logic g_last [64];
    int g_n;
    int hold_errs;
    int busy_errs;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [LANES-1:0] m, input logic [1:0] sz);
        @(negedge clk);
        for (int k = 0; k < LANES; k++) req_addr[k*AW +: AW] = lane_a[k];
        req_mask  = m;
        req_size  = sz;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic collect(input bit stall);
        int cyc = 0;
        logic prev_wait = 1'b0;
        logic [AW-1:0] prev_addr = '0;
        logic [LANES-1:0] prev_lanes = '0;
        g_n = 0; hold_errs = 0; busy_errs = 0;
        while (cyc < 200) begin
            if (prev_wait && (!txn_valid || txn_addr != prev_addr || txn_lanes != prev_lanes))
                hold_errs++;
            if (txn_valid && req_ready) busy_errs++;
            txn_ready = stall ? ((cyc % 3) == 2) : 1'b1;
            #1;
            if (txn_valid && txn_ready) begin
                g_addr[g_n] = txn_addr; g_bytes[g_n] = txn_bytes;
                g_lanes[g_n] = txn_lanes; g_last[g_n] = txn_last;
                g_n++;
            end
            prev_wait  = txn_valid && !txn_ready;
            prev_addr  = txn_addr;
            prev_lanes = txn_lanes;
            if (txn_valid && txn_ready && txn_last) cyc = 1000;
            else cyc++;
            @(negedge clk);
        end
        txn_ready = 1'b0;
    endtask

    task automatic expect_txn(input int i, input logic [AW-1:0] a, input int b,
                              input logic [LANES-1:0] l, input bit lst, input string tag);
        chk(g_addr[i] == a, {tag, " addr"}, g_addr[i], a);
        chk(g_bytes[i] == BW'(b), {tag, " bytes"}, g_bytes[i], b);
        chk(g_lanes[i] == l, {tag, " lanes"}, g_lanes[i], l);
        chk(g_last[i] == lst, {tag, " last R10"}, g_last[i], lst);
    endtask

    task automatic fill(input logic [AW-1:0] base, input int step);
        for (int k = 0; k < LANES; k++) lane_a[k] = base + AW'(k * step);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(txn_valid == 1'b0, "R1 txn_valid", txn_valid, 0);
    endtask

    task automatic t_full_word;
        fill(32'h1000, 4);
        send('1, 2'd2);
        collect(1'b0);
        chk(g_n == 3, "R3 chunk count", g_n, 3);
        expect_txn(0, 32'h1000, 48, 32'h0000_0FFF, 1'b0, "R3 R4 c0");
        expect_txn(1, 32'h1030, 48, 32'h00FF_F000, 1'b0, "R3 R4 c1");
        expect_txn(2, 32'h1060, 32, 32'hFF00_0000, 1'b1, "R2 R3 c2");
    endtask

    task automatic t_full_dword;
        fill(32'h2000, 8);
        send('1, 2'd3);
        collect(1'b0);
        chk(g_n == 6, "R5 chunk count", g_n, 6);
        for (int i = 0; i < 5; i++)
            expect_txn(i, 32'h2000 + AW'(48 * i), 48, 32'h3F << (6 * i), 1'b0, "R5 chunk");
        expect_txn(5, 32'h20F0, 16, 32'hC000_0000, 1'b1, "R5 tail");
    endtask

    task automatic t_sparse;
        fill(32'h4000, 4);
        for (int k = 0; k < LANES; k++)
            if (k < 3 || k > 20 || k == 10) lane_a[k] = 32'hDEAD_0000 + AW'(k * 7);
        send(32'h001F_FBF8, 2'd2);
        collect(1'b0);
        chk(g_n == 2, "R9 chunk count", g_n, 2);
        expect_txn(0, 32'h400C, 48, 32'h0000_7BF8, 1'b0, "R9 c0");
        expect_txn(1, 32'h403C, 24, 32'h001F_8000, 1'b1, "R9 c1");
    endtask

    task automatic t_narrow;
        fill(32'h0100, 1);
        send(32'h0000_000F, 2'd0);
        collect(1'b0);
        chk(g_n == 4, "R6 byte count", g_n, 4);
        for (int i = 0; i < 4; i++)
            expect_txn(i, 32'h0100 + AW'(i), 1, 32'h1 << i, i == 3, "R6 byte");
        fill(32'h0200, 2);
        send(32'h0000_0003, 2'd1);
        collect(1'b0);
        chk(g_n == 2, "R6 half count", g_n, 2);
        expect_txn(0, 32'h0200, 2, 32'h1, 1'b0, "R6 half0");
        expect_txn(1, 32'h0202, 2, 32'h2, 1'b1, "R6 half1");
    endtask

    task automatic t_misalign;
        fill(32'h1002, 4);
        send(32'h0000_000F, 2'd2);
        collect(1'b0);
        chk(g_n == 4, "R7 count", g_n, 4);
        for (int i = 0; i < 4; i++)
            expect_txn(i, 32'h1002 + AW'(4 * i), 4, 32'h1 << i, i == 3, "R7 lane");
    endtask

    task automatic t_scatter;
        for (int k = 0; k < LANES; k++) lane_a[k] = 32'h0800 - AW'(4 * k);
        send(32'h0000_0025, 2'd2);
        collect(1'b0);
        chk(g_n == 3, "R8 count", g_n, 3);
        expect_txn(0, 32'h0800, 4, 32'h01, 1'b0, "R8 lane0");
        expect_txn(1, 32'h07F8, 4, 32'h04, 1'b0, "R8 lane2");
        expect_txn(2, 32'h07EC, 4, 32'h20, 1'b1, "R8 lane5");
    endtask

    task automatic t_stall;
        fill(32'h3000, 4);
        send('1, 2'd2);
        collect(1'b1);
        chk(g_n == 3, "R11 count under stall", g_n, 3);
        chk(hold_errs == 0, "R11 outputs held", hold_errs, 0);
        chk(busy_errs == 0, "R11 ready low while busy", busy_errs, 0);
        expect_txn(2, 32'h3060, 32, 32'hFF00_0000, 1'b1, "R11 c2");
        chk(req_ready == 1'b1, "R11 ready after last", req_ready, 1);
    endtask

    task automatic t_empty;
        fill(32'h5000, 4);
        send('0, 2'd2);
        chk(txn_valid == 1'b0, "R12 no txn", txn_valid, 0);
        chk(req_ready == 1'b1, "R12 ready", req_ready, 1);
        @(negedge clk);
        chk(txn_valid == 1'b0, "R12 still none", txn_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_word();
        t_full_dword();
        t_sparse();
        t_narrow();
        t_misalign();
        t_scatter();
        t_stall();
        t_empty();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule